// File: doc/BRIEF.md
# Protected Clock Prescaler Register

This block holds the division factor that relates a master clock to the system clock, and produces the resulting divided clock-enable. Software reads and writes one 8-bit control register through a plain strobe-and-byte port. The register has a change-enable flag and a 4-bit division code. The code can only be altered through a guarded two-step sequence. First, a write of exactly `0x80` opens a short change window. Then a write with bit 7 clear, made while that window is open, loads the new code.

The window lasts a fixed four cycles. A second unlock write does not re-arm it. It closes at once when the code is loaded. The divider is a down-counter that raises its enable for one master cycle per divided period. It picks up a new factor only when the current period ends, so the enable never shows a shortened period. The register port is a plain control interface with a one-cycle write strobe and a combinational read. It has no valid/ready handshake and applies no back-pressure.

Top module: `clk_prescale_reg`

## Requirements
- R1: At reset the division code is loaded from `rst_code`, the change-enable flag is 0, and the divider runs at the factor of that code from the first period.
- R2: `rd_data` shows the flag in bit 7, zeros in bits 6:4 and the code in bits 3:0. Bits 6:4 of a write never appear on read.
- R3: Only a write of exactly `0x80` sets the flag. A write with bit 7 at one and any other bit nonzero changes neither the flag nor the code.
- R4: Once set, the flag stays high for exactly four cycles and is then cleared, unless the code is written first. A code write presented in the fourth cycle is still accepted.
- R5: Writing `0x80` again while the flag is set neither restarts the four-cycle timeout nor clears the flag.
- R6: A write with bit 7 at zero while the flag is set loads bits 3:0 into the code and clears the flag on the same edge.
- R7: A write with bit 7 at zero while the flag is clear leaves the code unchanged.
- R8: Codes 0 to 8 give a division of 2^code. `clk_en_o` is high for one cycle every 2^code cycles, and is always high for code 0.
- R9: Codes 9 to 15 are stored as written but divide by 1.
- R10: A new factor takes effect only after the current divided period has run its full length. No shortened period occurs.
- R11: `div_code_o` always equals the stored division code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register read value: flag, zeros, code |
| rst_code | input | 4 | Division code loaded during reset |
| clk_en_o | output | 1 | Divided clock-enable, one master cycle per period |
| div_code_o | output | 4 | Current stored division code |

## Verification
Two pairs of events can land on the same clock edge.

- The timeout expiry and a code write can coincide. The bench unlocks, idles three cycles and presents the code write in the fourth. It then expects the new code to be held and the flag to be low, so the load must win over the expiry. A write one cycle later must be ignored.
- A code change and a divider period boundary can meet. The bench switches from division by 256 to division by 1 in the middle of a period. A scoreboard of expected enable spacings then demands one full 256-cycle gap before the 1-cycle gaps appear.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DATA_W    = 8;
  localparam int CODE_W    = 4;
  localparam int MAX_SHIFT = 8;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = MAX_SHIFT;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [SHIFT_W-1:0] shift_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_UNLOCK,
    WR_LOAD,
    WR_REJECT
  } wr_kind_e;

  // Reserved codes above MAX_SHIFT map to division by one.
  function automatic shift_t code_to_shift(code_t c);
    if (int'(c) > MAX_SHIFT) return '0;
    return shift_t'(c);
  endfunction
endpackage

// File: rtl/psc_wr_decode.sv
module psc_wr_decode
  import psc_pkg::*;
(
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output wr_kind_e          kind
);
  logic rest_zero;

  assign rest_zero = (wr_data[DATA_W-2:0] == '0);

  always_comb begin
    if (!wr_en)                  kind = WR_IDLE;
    else if (wr_data[DATA_W-1])  kind = rest_zero ? WR_UNLOCK : WR_REJECT;
    else                         kind = WR_LOAD;
  end
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  wr_kind_e kind,
  input  code_t    wr_code,
  input  code_t    rst_code,
  output logic     window_open,
  output code_t    code
);
  localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_open <= 1'b0;
      remain      <= '0;
      code        <= rst_code;
    end else if (window_open) begin
      if (kind == WR_LOAD) begin
        code        <= wr_code;
        window_open <= 1'b0;
      end else if (remain == '0) begin
        window_open <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
      end
    end else if (kind == WR_UNLOCK) begin
      window_open <= 1'b1;
      remain      <= LAST;
    end
  end
endmodule

// File: rtl/psc_divider.sv
module psc_divider
  import psc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code,
  output logic  en_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  shift_t           nxt_shift;

  always_comb begin
    nxt_shift = code_to_shift(code);
    span      = {{CNT_W{1'b0}}, 1'b1} << nxt_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt <= CNT_W'(span - 1'b1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign en_o = (cnt == '0);
endmodule

// File: rtl/clk_prescale_reg.sv
module clk_prescale_reg
  import psc_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [3:0] rst_code,
  output logic       clk_en_o,
  output logic [3:0] div_code_o
);
  wr_kind_e kind;
  logic     window_open;
  code_t    code;

  psc_wr_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .kind    (kind)
  );

  psc_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .wr_code     (wr_data[CODE_W-1:0]),
    .rst_code    (rst_code),
    .window_open (window_open),
    .code        (code)
  );

  psc_divider u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .code (code),
    .en_o (clk_en_o)
  );

  assign rd_data    = {window_open, {(DATA_W-1-CODE_W){1'b0}}, code};
  assign div_code_o = code;
endmodule

// File: rtl/psc_checker.sv
module psc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       clk_en_o,
  input logic [3:0] div_code_o
);
  logic flag;
  assign flag = rd_data[7];

  // R4: four consecutive cycles high, then the flag must drop
  a_r4_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && $past(flag) && $past(flag, 2) && $past(flag, 3)) |=> !flag);

  // R3: nothing but the exact unlock pattern raises a closed flag
  a_r3_exact_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(wr_en && wr_data == 8'h80)) |=> !flag);

  // R3: a malformed unlock write leaves the code alone
  a_r3_reject_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && wr_data[6:0] != 7'd0) |=> $stable(div_code_o));

  // R6: a code write in the window loads and closes it
  a_r6_load_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_en && !wr_data[7]) |=> (!flag && div_code_o == $past(wr_data[3:0])));

  // R7: with the window shut the code cannot move
  a_r7_locked_code: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> $stable(div_code_o));

  // R8: code zero at a period end gives another enable next cycle
  a_r8_div_one: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o && div_code_o == 4'd0) |=> clk_en_o);

  // R9: reserved codes at a period end also give division by one
  a_r9_reserved_div_one: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o && div_code_o > 4'd8) |=> clk_en_o);
endmodule

bind clk_prescale_reg psc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .clk_en_o   (clk_en_o),
  .div_code_o (div_code_o)
);

// File: tb/clk_prescale_reg_test.sv
module clk_prescale_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] rst_code = 4'd3;
  logic       clk_en_o;
  logic [3:0] div_code_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_pulse = 0;
  int    exp_q[$];
  string req_q[$];

  clk_prescale_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rst_code(rst_code), .clk_en_o(clk_en_o),
    .div_code_o(div_code_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: measures spacing between enable pulses, pops expected gaps
  always @(negedge clk) begin
    if (rst_n && clk_en_o) begin
      if (exp_q.size() > 0) check(req_q.pop_front(), cyc - last_pulse, exp_q.pop_front());
      last_pulse = cyc;
    end
  end

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_code(logic [3:0] c);
    wr(8'h80);
    wr({4'h0, c});
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (!clk_en_o) @(negedge clk);
    #1;
  endtask

  task automatic push_gaps(string req, int gap, int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(gap);
      req_q.push_back(req);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic expect_div(string req, logic [3:0] c, int gap);
    set_code(c);
    check({req, "_code"}, div_code_o, c);
    wait_pulse();
    wait_pulse();
    push_gaps(req, gap, 3);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1_reset_read", rd_data, 8'h03);
    check("R11_reset_code", div_code_o, 3);
    wait_pulse(); wait_pulse();
    push_gaps("R1_reset_div8", 8, 2);
    drain();

    wr(8'h05);
    check("R7_locked_write", rd_data, 8'h03);
    wr(8'h81);
    check("R3_bad_unlock", rd_data, 8'h03);
    wr(8'h80);
    check("R3_R2_unlock_read", rd_data, 8'h83);
    wr(8'h85);
    check("R3_bad_in_window", rd_data, 8'h83);
    idle(2);
    check("R4_still_open", rd_data, 8'h83);
    idle(1);
    check("R4_timed_out", rd_data, 8'h03);

    wr(8'h80); idle(4);
    check("R4_closed_after_4", rd_data, 8'h03);
    wr(8'h01);
    check("R7_late_write", rd_data, 8'h03);

    wr(8'h80); wr(8'h80);
    check("R5_rearm_no_clear", rd_data, 8'h83);
    idle(2);
    check("R5_rearm_open", rd_data, 8'h83);
    idle(1);
    check("R5_no_extend", rd_data, 8'h03);

    wr(8'h80); idle(3); wr(8'h02);
    check("R6_last_cycle_load", rd_data, 8'h02);
    check("R11_code_out", div_code_o, 2);

    wr(8'h80); wr(8'h75);
    check("R6_R2_load_masks", rd_data, 8'h05);
    wr(8'h03);
    check("R6_closed_after_load", rd_data, 8'h05);
    wait_pulse(); wait_pulse();
    push_gaps("R8_div32", 32, 2);
    drain();

    expect_div("R8_div1", 4'd0, 1);
    expect_div("R8_div2", 4'd1, 2);
    expect_div("R8_div256", 4'd8, 256);

    wait_pulse();
    push_gaps("R10_full_old_period", 256, 1);
    push_gaps("R10_new_factor", 1, 2);
    set_code(4'd0);
    drain();

    expect_div("R9_code12", 4'd12, 1);
    expect_div("R9_code15", 4'd15, 1);
    check("R11_reserved_stored", rd_data, 8'h0F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule